// File: doc/BRIEF.md
# Multi-Issue Register Hazard Matrix

This block tracks register hazards for an out-of-order core. A batch of up to `ISSUE` decoded operations is offered each cycle. Each operation names two source registers and one destination register. An accepted operation takes a free slot in a small matrix of in-flight entries. Its row in three bit matrices records which older entries it waits on: read-after-write, write-after-read and write-after-write. Every entry is older than any operation that arrives later, so a dependency bit always points at an older operation.

Each entry shows two grants. `go_rd` means its source operands are safe to read. `go_wr` means its result is safe to write. The surrounding pipeline pulses `rd_done` when the entry has read its operands. It pulses `wr_done` when the entry has written its result. A `wr_done` pulse frees the entry and removes its column from every row. A `rd_done` pulse removes only its write-after-read column.

Operations in the same batch may share registers. The matrix orders them in slot order, as if each had arrived one cycle after the previous one. When a later slot conflicts with an earlier slot, it also takes on that slot's whole dependency rows. This follows from the fact that dependencies are transitive.

Top module: `depmat_top`

## Requirements
- R1: An entry whose source register equals the destination of an older entry that has not yet written keeps `go_rd` low. `go_rd` stays low until the cycle after that writer's `wr_done`.
- R2: An entry keeps `go_wr` low while an older entry that reads the entry's destination register has not yet pulsed `rd_done`. `go_wr` may rise in the cycle after that `rd_done`.
- R3: An entry keeps `go_wr` low while an older entry with the same destination register has not yet written. `go_wr` may rise in the cycle after that entry's `wr_done`.
- R4: `iss_ready` is 1 exactly when the number of free entries is at least the number of set bits in `iss_valid`. The whole batch is then taken at the clock edge; otherwise none of it is taken. The valid slots, in rising slot order, receive the free entries in rising index order, and `iss_idx[k]` gives slot k's entry.
- R5: A batch is accepted even when its operations share registers. Each slot is ordered after every lower slot of the same batch exactly as R1 to R3 order it after older entries. A later slot that conflicts with a lower slot also inherits that slot's dependency rows. Any legal completion order therefore leaves the same register contents as in-order execution.
- R6: Register number 0 never creates a read-after-write, write-after-read or write-after-write dependency.
- R7: `go_rd` is high for a valid entry that has not read and has no read dependency left. `go_wr` is high for a valid entry that has already read and has no write dependency left. `rd_done`/`wr_done` may be pulsed only for an entry whose `go_rd`/`go_wr` is high.
- R8: `wr_done` frees the entry from the next cycle on. In that same edge, its column is cleared from every other entry's rows.
- R9: After reset every entry is free, `go_rd` and `go_wr` are all 0, and `iss_ready` is 1 for a full batch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | ISSUE | Per-slot valid of the offered batch |
| iss_src1 | input | ISSUE x RW | First source register per slot |
| iss_src2 | input | ISSUE x RW | Second source register per slot |
| iss_dst | input | ISSUE x RW | Destination register per slot |
| iss_ready | output | 1 | Whole batch fits and is taken at this edge |
| iss_idx | output | ISSUE x IW | Entry assigned to each slot |
| rd_done | input | ENTRIES | Entry has read its operands |
| wr_done | input | ENTRIES | Entry has written its result; frees it |
| go_rd | output | ENTRIES | Entry may read its operands |
| go_wr | output | ENTRIES | Entry may write its result |

## Verification
The bench builds the block with its defaults: two slots, eight entries and 32 registers. Random operations use only registers 0 to 7, so nearly every batch has read-after-write, write-after-read and write-after-write conflicts, both inside the batch and against older entries. Eight entries let the bench fill the matrix in a few cycles, which brings the exact-fit and stalled-batch cases within reach. The random phase completes reads and writes at random and compares every written value with an in-order model of the same program.

// File: rtl/depmat_pkg.sv
package depmat_pkg;
  localparam int DM_ISSUE   = 2;
  localparam int DM_ENTRIES = 8;
  localparam int DM_REGS    = 32;

  // A register pair conflicts when both name the same non-zero register (R6).
  function automatic logic reg_hit(input logic [7:0] a, input logic [7:0] b);
    return (a == b) && (a != 8'd0);
  endfunction

  // Hazard of a younger op (ys1, ys2, yd) on an older op (os1, os2, od).
  typedef struct packed {
    logic raw;
    logic war;
    logic waw;
  } hazard_t;

  function automatic hazard_t pair_hazard(input logic [7:0] ys1, input logic [7:0] ys2,
                                          input logic [7:0] yd,  input logic [7:0] os1,
                                          input logic [7:0] os2, input logic [7:0] od);
    hazard_t h;
    h.raw = reg_hit(ys1, od) | reg_hit(ys2, od);
    h.war = reg_hit(yd, os1) | reg_hit(yd, os2);
    h.waw = reg_hit(yd, od);
    return h;
  endfunction
endpackage

// File: rtl/depmat_alloc.sv
module depmat_alloc
  import depmat_pkg::*;
#(
  parameter int ISSUE   = DM_ISSUE,
  parameter int ENTRIES = DM_ENTRIES,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]         free_vec,
  input  logic [ISSUE-1:0]           slot_v,
  output logic                       fits,
  output logic [ISSUE-1:0]           take,
  output logic [ISSUE-1:0][IW-1:0]   slot_idx
);
  int n_free;
  int n_req;

  always_comb begin
    n_free = 0;
    n_req  = 0;
    for (int e = 0; e < ENTRIES; e++) n_free += int'(free_vec[e]);
    for (int k = 0; k < ISSUE; k++)   n_req  += int'(slot_v[k]);
    fits = (n_free >= n_req);
  end

  // Slot k takes the c-th free entry, c = number of valid lower slots.
  always_comb begin
    for (int k = 0; k < ISSUE; k++) begin
      int rank;
      int seen;
      logic found;
      rank  = 0;
      seen  = 0;
      found = 1'b0;
      for (int j = 0; j < k; j++) rank += int'(slot_v[j]);
      slot_idx[k] = '0;
      for (int e = 0; e < ENTRIES; e++) begin
        if (free_vec[e] && !found) begin
          if (seen == rank) begin
            slot_idx[k] = IW'(e);
            found = 1'b1;
          end
          seen++;
        end
      end
      take[k] = slot_v[k] & fits;
    end
  end
endmodule

// File: rtl/depmat_match.sv
module depmat_match
  import depmat_pkg::*;
#(
  parameter int ENTRIES = DM_ENTRIES,
  parameter int RW      = $clog2(DM_REGS)
) (
  input  logic [RW-1:0]               src1,
  input  logic [RW-1:0]               src2,
  input  logic [RW-1:0]               dst,
  input  logic [ENTRIES-1:0]          live,
  input  logic [ENTRIES-1:0]          rd_pending,
  input  logic [ENTRIES-1:0][RW-1:0]  ent_src1,
  input  logic [ENTRIES-1:0][RW-1:0]  ent_src2,
  input  logic [ENTRIES-1:0][RW-1:0]  ent_dst,
  output logic [ENTRIES-1:0]          raw,
  output logic [ENTRIES-1:0]          war,
  output logic [ENTRIES-1:0]          waw
);
  for (genvar j = 0; j < ENTRIES; j++) begin : g_col
    hazard_t h;
    assign h = pair_hazard(8'(src1), 8'(src2), 8'(dst),
                           8'(ent_src1[j]), 8'(ent_src2[j]), 8'(ent_dst[j]));
    assign raw[j] = live[j] & h.raw;        // R1
    assign war[j] = rd_pending[j] & h.war;  // R2
    assign waw[j] = live[j] & h.waw;        // R3
  end
endmodule

// File: rtl/depmat_top.sv
module depmat_top
  import depmat_pkg::*;
#(
  parameter int ISSUE   = DM_ISSUE,
  parameter int ENTRIES = DM_ENTRIES,
  parameter int REGS    = DM_REGS,
  localparam int RW     = $clog2(REGS),
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ISSUE-1:0]          iss_valid,
  input  logic [ISSUE-1:0][RW-1:0]  iss_src1,
  input  logic [ISSUE-1:0][RW-1:0]  iss_src2,
  input  logic [ISSUE-1:0][RW-1:0]  iss_dst,
  output logic                      iss_ready,
  output logic [ISSUE-1:0][IW-1:0]  iss_idx,
  input  logic [ENTRIES-1:0]        rd_done,
  input  logic [ENTRIES-1:0]        wr_done,
  output logic [ENTRIES-1:0]        go_rd,
  output logic [ENTRIES-1:0]        go_wr
);
  typedef logic [ENTRIES-1:0] row_t;

  logic [ENTRIES-1:0]          valid_q, rdp_q;
  logic [ENTRIES-1:0][RW-1:0]  s1_q, s2_q, dst_q;
  row_t                        raw_q [ENTRIES];
  row_t                        war_q [ENTRIES];
  row_t                        waw_q [ENTRIES];

  // Named internal events
  logic [ENTRIES-1:0] live_w, rdpend_w, free_w, col_raw_w, col_waw_w;
  logic [ISSUE-1:0]   take_w;
  row_t               m_raw [ISSUE];
  row_t               m_war [ISSUE];
  row_t               m_waw [ISSUE];
  row_t               n_raw [ISSUE];
  row_t               n_war [ISSUE];
  row_t               n_waw [ISSUE];

  assign live_w   = valid_q & ~wr_done;
  assign rdpend_w = valid_q & rdp_q & ~rd_done;
  assign free_w   = ~valid_q;

  depmat_alloc #(.ISSUE(ISSUE), .ENTRIES(ENTRIES)) u_alloc (
    .free_vec(free_w), .slot_v(iss_valid), .fits(iss_ready),
    .take(take_w), .slot_idx(iss_idx)
  );

  for (genvar k = 0; k < ISSUE; k++) begin : g_slot
    depmat_match #(.ENTRIES(ENTRIES), .RW(RW)) u_match (
      .src1(iss_src1[k]), .src2(iss_src2[k]), .dst(iss_dst[k]),
      .live(live_w), .rd_pending(rdpend_w),
      .ent_src1(s1_q), .ent_src2(s2_q), .ent_dst(dst_q),
      .raw(m_raw[k]), .war(m_war[k]), .waw(m_waw[k])
    );
  end

  // In-batch ordering with inheritance of the lower slot's rows (R5).
  always_comb begin
    for (int k = 0; k < ISSUE; k++) begin
      n_raw[k] = m_raw[k];
      n_war[k] = m_war[k];
      n_waw[k] = m_waw[k];
      for (int j = 0; j < k; j++) begin
        hazard_t h;
        h = pair_hazard(8'(iss_src1[k]), 8'(iss_src2[k]), 8'(iss_dst[k]),
                        8'(iss_src1[j]), 8'(iss_src2[j]), 8'(iss_dst[j]));
        if (take_w[j]) begin
          if (h.raw) n_raw[k][iss_idx[j]] = 1'b1;
          if (h.war) n_war[k][iss_idx[j]] = 1'b1;
          if (h.waw) n_waw[k][iss_idx[j]] = 1'b1;
          if (h.raw | h.war | h.waw) begin
            n_raw[k] = n_raw[k] | n_raw[j];
            n_war[k] = n_war[k] | n_war[j];
            n_waw[k] = n_waw[k] | n_waw[j];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      rdp_q   <= '0;
      s1_q    <= '0;
      s2_q    <= '0;
      dst_q   <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        raw_q[i] <= '0;
        war_q[i] <= '0;
        waw_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        valid_q[i] <= valid_q[i] & ~wr_done[i];
        rdp_q[i]   <= rdp_q[i] & ~rd_done[i] & ~wr_done[i];
        raw_q[i]   <= wr_done[i] ? '0 : (raw_q[i] & ~wr_done);
        war_q[i]   <= wr_done[i] ? '0 : (war_q[i] & ~rd_done & ~wr_done);
        waw_q[i]   <= wr_done[i] ? '0 : (waw_q[i] & ~wr_done);
      end
      for (int k = 0; k < ISSUE; k++) begin
        if (take_w[k]) begin
          valid_q[iss_idx[k]] <= 1'b1;
          rdp_q[iss_idx[k]]   <= 1'b1;
          s1_q[iss_idx[k]]    <= iss_src1[k];
          s2_q[iss_idx[k]]    <= iss_src2[k];
          dst_q[iss_idx[k]]   <= iss_dst[k];
          raw_q[iss_idx[k]]   <= n_raw[k];
          war_q[iss_idx[k]]   <= n_war[k];
          waw_q[iss_idx[k]]   <= n_waw[k];
        end
      end
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_go
    assign go_rd[i] = valid_q[i] & rdp_q[i] & ~|raw_q[i];
    assign go_wr[i] = valid_q[i] & ~rdp_q[i] & ~|war_q[i] & ~|waw_q[i];
  end

  always_comb begin
    col_raw_w = '0;
    col_waw_w = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      col_raw_w = col_raw_w | raw_q[i];
      col_waw_w = col_waw_w | waw_q[i];
    end
  end

  // Assertions
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ast_ent
    AST_RD_DONE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done[i] |-> go_rd[i]); // R7
    AST_WR_DONE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done[i] |-> go_wr[i]); // R7
    AST_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done[i] |=> !valid_q[i]); // R8
    AST_COLUMN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done[i] |=> !col_raw_w[i] && !col_waw_w[i]); // R8
    AST_NO_SELF_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      !raw_q[i][i] && !war_q[i][i] && !waw_q[i][i]); // R5
  end

  for (genvar k = 0; k < ISSUE; k++) begin : g_ast_slot
    AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      take_w[k] |-> !valid_q[iss_idx[k]]); // R4
    AST_ZERO_REG_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (take_w[k] && iss_src1[k] == '0 && iss_src2[k] == '0 && iss_dst[k] == '0)
      |=> raw_q[$past(iss_idx[k])] == '0 && war_q[$past(iss_idx[k])] == '0
          && waw_q[$past(iss_idx[k])] == '0); // R6
  end

  AST_STALL_ONLY_WHEN_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_ready |-> $countones(iss_valid) > $countones(~valid_q)); // R4
  AST_OCCUPANCY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(valid_q) == $past($countones(valid_q)) + $past($countones(take_w))
             - $past($countones(wr_done & valid_q))); // R4
endmodule

// File: tb/depmat_top_test.sv
module depmat_top_test;
  localparam int N  = 2;
  localparam int E  = 8;
  localparam int RW = 5;
  localparam int IW = 3;
  localparam int NUM_OPS = 1500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]         iss_valid = '0;
  logic [N-1:0][RW-1:0] iss_src1 = '0, iss_src2 = '0, iss_dst = '0;
  logic                 iss_ready;
  logic [N-1:0][IW-1:0] iss_idx;
  logic [E-1:0]         rd_done = '0, wr_done = '0, go_rd, go_wr;

  always #2.5 clk = ~clk;  // 200 MHz

  depmat_top uut (
    .clk, .rst_n, .iss_valid, .iss_src1, .iss_src2, .iss_dst, .iss_ready,
    .iss_idx, .rd_done, .wr_done, .go_rd, .go_wr
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  typedef struct { int unsigned seq; logic [31:0] val; } exp_t;
  exp_t exp_q[$];

  logic [31:0] rf   [8];
  logic [31:0] gold [8];
  logic [RW-1:0] e_s1 [E], e_s2 [E], e_d [E];
  int unsigned   e_seq [E];
  logic [31:0]   e_a [E], e_b [E];

  function automatic logic [31:0] op_result(logic [31:0] a, logic [31:0] b, int unsigned seq);
    return a * 32'd3 + (b ^ 32'h5a5a_0000) + seq;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    iss_valid = '0;
    rd_done   = '0;
    wr_done   = '0;
  endtask

  task automatic set_slot(int k, int s1, int s2, int d);
    iss_valid[k] = 1'b1;
    iss_src1[k]  = RW'(s1);
    iss_src2[k]  = RW'(s2);
    iss_dst[k]   = RW'(d);
  endtask

  // Monitor: pops the expected item of this op and compares the written value.
  task automatic mon_write(int unsigned seq, logic [31:0] val);
    int hit;
    hit = -1;
    foreach (exp_q[q]) if (exp_q[q].seq == seq && hit < 0) hit = q;
    if (hit < 0) check("R5 write seen", 64'(seq), 64'hFFFF_FFFF);
    else begin
      check("R5 in-order value", 64'(val), 64'(exp_q[hit].val));
      exp_q.delete(hit);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seq;
    int issued, outstanding, guard;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R9 reset state
    check("R9 go_rd", 64'(go_rd), 64'h0);
    check("R9 go_wr", 64'(go_wr), 64'h0);
    set_slot(0, 2, 3, 1);   // A: r1 <- r2,r3
    set_slot(1, 1, 0, 4);   // B: r4 <- r1,r0 (RAW on A in batch)
    #1;
    check("R9 ready full batch", 64'(iss_ready), 64'h1);
    check("R4 slot0 idx", 64'(iss_idx[0]), 64'd0);
    check("R4 slot1 idx", 64'(iss_idx[1]), 64'd1);
    tick();
    check("R1 R5 B waits on A", 64'(go_rd), 64'h01);
    check("R7 no write yet", 64'(go_wr), 64'h00);
    set_slot(0, 5, 6, 3);   // C: r3 <- r5,r6 (WAR vs A reading r3)
    #1;
    check("R4 C idx", 64'(iss_idx[0]), 64'd2);
    tick();
    check("R7 go_rd A C", 64'(go_rd), 64'h05);
    rd_done = 8'h04;
    tick();
    check("R2 C write held by A read", 64'(go_wr), 64'h00);
    rd_done = 8'h01;
    tick();
    check("R2 R7 A and C may write", 64'(go_wr), 64'h05);
    check("R1 B still waits", 64'(go_rd), 64'h00);
    set_slot(0, 0, 0, 1);   // E: r1 <- r0,r0 (WAW vs A, WAR vs B)
    wr_done = 8'h01;
    #1;
    check("R4 E idx", 64'(iss_idx[0]), 64'd3);
    tick();
    check("R1 R8 B released, E reads", 64'(go_rd), 64'h0A);
    rd_done = 8'h08;
    wr_done = 8'h04;
    tick();
    check("R2 E held by B read", 64'(go_wr), 64'h00);
    rd_done = 8'h02;
    tick();
    check("R2 B and E may write", 64'(go_wr), 64'h0A);
    wr_done = 8'h0A;
    set_slot(0, 0, 0, 7);   // F
    set_slot(1, 0, 0, 7);   // G, WAW on F within batch
    #1;
    check("R4 lowest free slot0", 64'(iss_idx[0]), 64'd0);
    check("R4 lowest free slot1", 64'(iss_idx[1]), 64'd2);
    tick();
    check("R5 shared-dst batch reads", 64'(go_rd), 64'h05);
    rd_done = 8'h05;
    tick();
    check("R3 G waits for F", 64'(go_wr), 64'h01);
    wr_done = 8'h01;
    tick();
    check("R3 G released", 64'(go_wr), 64'h04);
    wr_done = 8'h04;
    tick();
    check("R8 all free", 64'(go_rd | go_wr), 64'h0);
    // R6: register 0 creates nothing
    set_slot(0, 8, 9, 0);   // P
    set_slot(1, 0, 0, 0);   // Q
    tick();
    check("R6 both read", 64'(go_rd), 64'h03);
    rd_done = 8'h02;
    tick();
    check("R6 Q writes before P reads", 64'(go_wr), 64'h02);
    wr_done = 8'h02;
    rd_done = 8'h01;
    tick();
    check("R6 P writes", 64'(go_wr), 64'h01);
    wr_done = 8'h01;
    tick();
    // R4 stall behaviour
    for (int b = 0; b < 3; b++) begin
      set_slot(0, 0, 0, 0);
      set_slot(1, 0, 0, 0);
      tick();
    end
    iss_valid = 2'b10;
    #1;
    check("R4 lone slot1 idx", 64'(iss_idx[1]), 64'd6);
    tick();
    iss_valid = 2'b11;
    #1;
    check("R4 stall short by one", 64'(iss_ready), 64'h0);
    iss_valid = 2'b01;
    #1;
    check("R4 exact fit", 64'(iss_ready), 64'h1);
    check("R4 last idx", 64'(iss_idx[0]), 64'd7);
    tick();
    iss_valid = 2'b01;
    #1;
    check("R4 full stalls", 64'(iss_ready), 64'h0);
    tick();
    check("R6 R7 all read", 64'(go_rd), 64'hFF);
    rd_done = 8'hFF;
    tick();
    check("R7 all write", 64'(go_wr), 64'hFF);
    wr_done = 8'hFF;
    tick();
    check("R8 drained", 64'(go_rd | go_wr), 64'h0);

    // Random program versus in-order model
    for (int r = 0; r < 8; r++) begin
      rf[r]   = (r == 0) ? 32'h0 : 32'h100 * r;
      gold[r] = rf[r];
    end
    seq = 0; issued = 0; outstanding = 0; guard = 0;
    while ((issued < NUM_OPS || outstanding > 0) && guard < 100000) begin
      guard++;
      for (int i = 0; i < E; i++) begin
        if (go_rd[i] && ($urandom % 2 == 0)) begin
          rd_done[i] = 1'b1;
          e_a[i] = rf[e_s1[i][2:0]];
          e_b[i] = rf[e_s2[i][2:0]];
        end else if (go_wr[i] && ($urandom % 3 != 0)) begin
          logic [31:0] v;
          wr_done[i] = 1'b1;
          v = op_result(e_a[i], e_b[i], e_seq[i]);
          if (e_d[i] != 0) rf[e_d[i][2:0]] = v;
          mon_write(e_seq[i], v);
          outstanding--;
        end
      end
      if (issued < NUM_OPS) begin
        logic [N-1:0] v;
        v = N'($urandom % 4);
        if (issued == NUM_OPS - 1) v[1] = 1'b0;
        for (int k = 0; k < N; k++)
          if (v[k]) set_slot(k, $urandom % 8, $urandom % 8, $urandom % 8);
        #1;
        if (iss_ready) begin
          for (int k = 0; k < N; k++) if (v[k]) begin
            logic [31:0] g;
            e_s1[iss_idx[k]] = iss_src1[k];
            e_s2[iss_idx[k]] = iss_src2[k];
            e_d[iss_idx[k]]  = iss_dst[k];
            e_seq[iss_idx[k]] = seq;
            g = op_result(gold[iss_src1[k][2:0]], gold[iss_src2[k][2:0]], seq);
            if (iss_dst[k] != 0) gold[iss_dst[k][2:0]] = g;
            exp_q.push_back('{seq, g});
            seq++; issued++; outstanding++;
          end
        end
      end
      tick();
    end
    check("R5 random run drained", 64'(outstanding), 64'd0);
    check("R5 no pending expectations", 64'(exp_q.size()), 64'd0);
    for (int r = 1; r < 8; r++) check("R5 final register", 64'(rf[r]), 64'(gold[r]));
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule